// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a watchdog built around a down-counter. The counter decrements once per tick of a prescaler, and the prescaler divides the CPU clock. Software keeps the watchdog from expiring by writing a two-byte key to a refresh register: first 00h, then FFh. No other write reloads the counter. Reset also reloads it, and so does its own underflow. The prescaler is never cleared by a refresh, so a timeout measured from a refresh can be off by up to one prescaler period.

Static configuration inputs set four things:
- the reload value, picked from four options;
- the division ratio, 16 or 128, or 2 when a low-speed clock is in use;
- whether counting starts right after reset or waits for a write to a start register;
- what an underflow does: it either pulses an interrupt request for one cycle or raises a reset request that stays high until reset.

A hold input freezes the prescaler and the counter without losing their values, for use during stop or wait modes. Once counting has started, software cannot stop it.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst` is high and in the cycle after it, `irq_o` and `rst_req_o` are 0, and the counter is loaded with the selected reload value m.
- R2: The division ratio n is 16 when `div_sel_i`=0 and 128 when `div_sel_i`=1. The counter moves once every n enabled cycles. The first underflow comes n×(m+1) enabled cycles after counting starts, so n=16 with m=3FFFh gives 262144 cycles.
- R3: When `lowspd_i`=1, n is forced to 2, whatever `div_sel_i` is.
- R4: `cfg_reload_sel_i` selects m as follows: 00b gives 03FFh, 01b gives 0FFFh, 10b gives 1FFFh, and 11b gives 3FFFh.
- R5: A write of 00h to address 0 (the refresh register), followed directly by a write of FFh to address 0, reloads the counter with m on the FFh write.
- R6: Any other data value written to address 0 disarms the key. An FFh that does not directly follow a 00h write to address 0 has no effect. Writes to other addresses leave the key state unchanged.
- R7: A refresh does not clear the prescaler. After a refresh at enabled cycle k, the underflow comes at the (m+1)-th prescaler tick after k, and the ticks keep their phase from the start of counting.
- R8: When `cfg_start_wait_i`=0, counting begins on the first clock after reset. When it is 1, counting waits until any write to address 1 (the start register). Further start writes have no effect, and nothing but reset stops the count.
- R9: While `hold_i`=1, the prescaler and the counter keep their values. When `hold_i` returns to 0, counting resumes from those values.
- R10: When `cfg_rst_mode_i`=0, an underflow produces a one-cycle pulse on `irq_o`. The counter then reloads, so underflows repeat every n×(m+1) enabled cycles.
- R11: When `cfg_rst_mode_i`=1, an underflow sets `rst_req_o`, which stays high until `rst`. `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 = refresh key, 1 = start |
| wr_data_i | input | 8 | Write data |
| cfg_start_wait_i | input | 1 | 1 = wait for a start write; 0 = run from reset |
| cfg_reload_sel_i | input | 2 | Reload value select |
| cfg_rst_mode_i | input | 1 | 1 = underflow requests reset; 0 = underflow interrupts |
| div_sel_i | input | 1 | Prescaler select: 0 = /16, 1 = /128 |
| lowspd_i | input | 1 | Low-speed clock in use; forces /2 |
| hold_i | input | 1 | Freeze counting (stop/wait) |
| irq_o | output | 1 | One-cycle watchdog interrupt pulse |
| rst_req_o | output | 1 | Sticky watchdog reset request |

## Verification
The bench measures the exact enabled cycle of the first underflow for each reload code and each division ratio. A design with an off-by-one in the period, or with swapped codes, therefore misses the expected cycle.

In one case the refresh lands mid-way through a prescaler period. That timing is expected to move by 16 cycles, not 20. A design that clears the prescaler on refresh lands four cycles late.

Broken key sequences (00h, 55h, FFh) must leave the original timeout unchanged. A design that stays armed across a stray value reloads early.

The bench also covers the remaining behaviours:
- a start-mode wait during which no underflow may occur;
- a second start write that must not restart the count;
- a hold window that must shift the underflow by exactly its length;
- reset mode, where an interrupt that leaks out, or a request that drops, is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned KEY_ADDR   = 0;
  localparam int unsigned START_ADDR = 1;
  localparam logic [7:0]  KEY_ARM    = 8'h00;
  localparam logic [7:0]  KEY_FIRE   = 8'hFF;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_LO   = 16,
  parameter int unsigned DIV_HI   = 128,
  parameter int unsigned DIV_SLOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic div_sel_i,
  input  logic lowspd_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(DIV_HI);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  // terminal count for the active ratio; slow clock overrides the select
  always_comb begin
    if (lowspd_i)       lim = PRE_W'(DIV_SLOW - 1);
    else if (div_sel_i) lim = PRE_W'(DIV_HI - 1);
    else                lim = PRE_W'(DIV_LO - 1);
  end

  assign tick_o = en_i && (pre_q >= lim);

  // cleared only by reset; a refresh leaves the phase alone
  always_ff @(posedge clk) begin
    if (rst)         pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else if (en_i)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_keyctl.sv
module wdog_keyctl #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              refresh_o,
  output logic              start_o
);
  import wdog_pkg::*;

  logic key_hit;
  logic armed_q;

  assign key_hit   = wr_en_i && (wr_addr_i == ADDR_W'(KEY_ADDR));
  assign start_o   = wr_en_i && (wr_addr_i == ADDR_W'(START_ADDR));
  assign refresh_o = key_hit && armed_q && (wr_data_i == KEY_FIRE);

  // any key write re-evaluates the armed state; other addresses leave it
  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (key_hit) armed_q <= (wr_data_i == KEY_ARM);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned RELOAD0 = 'h03FF,
  parameter int unsigned RELOAD1 = 'h0FFF,
  parameter int unsigned RELOAD2 = 'h1FFF,
  parameter int unsigned RELOAD3 = 'h3FFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_i,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_val_o,
  output logic             uf_o
);
  localparam int unsigned NSEL = 4;

  logic [CNT_W-1:0] opt [NSEL];
  logic [CNT_W-1:0] cnt_q;

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_opt
      localparam int unsigned VAL = (i == 0) ? RELOAD0 :
                                    (i == 1) ? RELOAD1 :
                                    (i == 2) ? RELOAD2 : RELOAD3;
      assign opt[i] = CNT_W'(VAL);
    end
  endgenerate

  assign reload_val_o = opt[sel_i];
  // a refresh on the same edge wins over an underflow
  assign uf_o = tick_i && (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= reload_val_o;
    else if (reload_i) cnt_q <= reload_val_o;
    else if (uf_o)     cnt_q <= reload_val_o;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned DIV_LO   = 16,
  parameter int unsigned DIV_HI   = 128,
  parameter int unsigned DIV_SLOW = 2,
  parameter int unsigned RELOAD0  = 'h03FF,
  parameter int unsigned RELOAD1  = 'h0FFF,
  parameter int unsigned RELOAD2  = 'h1FFF,
  parameter int unsigned RELOAD3  = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cfg_start_wait_i,
  input  logic [1:0]        cfg_reload_sel_i,
  input  logic              cfg_rst_mode_i,
  input  logic              div_sel_i,
  input  logic              lowspd_i,
  input  logic              hold_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             running_q;
  logic             en;
  logic             tick;
  logic             refresh;
  logic             start;
  logic             uf;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_val;

  // start latch: only reset can clear it
  always_ff @(posedge clk) begin
    if (rst)        running_q <= ~cfg_start_wait_i;
    else if (start) running_q <= 1'b1;
  end

  assign en = running_q && !hold_i;

  wdog_keyctl #(.ADDR_W(ADDR_W)) u_key (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .refresh_o (refresh),
    .start_o   (start)
  );

  wdog_prescaler #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .DIV_SLOW(DIV_SLOW)
  ) u_pre (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en),
    .div_sel_i (div_sel_i),
    .lowspd_i  (lowspd_i),
    .tick_o    (tick)
  );

  wdog_counter #(
    .CNT_W(CNT_W), .RELOAD0(RELOAD0), .RELOAD1(RELOAD1),
    .RELOAD2(RELOAD2), .RELOAD3(RELOAD3)
  ) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (cfg_reload_sel_i),
    .tick_i       (tick),
    .reload_i     (refresh),
    .cnt_o        (cnt),
    .reload_val_o (reload_val),
    .uf_o         (uf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o <= uf && !cfg_rst_mode_i;
      if (uf && cfg_rst_mode_i) rst_req_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_i,
  input logic             running_q,
  input logic             tick,
  input logic             refresh,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             cfg_rst_mode_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload_val
);
  // R10
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R11
  rst_req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> rst_req_o);

  // R11
  no_irq_in_rst_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_mode_i |=> !irq_o);

  // R9
  hold_freezes_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i || !running_q) |=> $stable(cnt));

  // R2
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt != '0) && !refresh) |=> (cnt == $past(cnt) - 1'b1));

  // R5
  refresh_reload_chk: assert property (@(posedge clk) disable iff (rst)
    refresh |=> (cnt == $past(reload_val)));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .hold_i         (hold_i),
  .running_q      (running_q),
  .tick           (tick),
  .refresh        (refresh),
  .irq_o          (irq_o),
  .rst_req_o      (rst_req_o),
  .cfg_rst_mode_i (cfg_rst_mode_i),
  .cnt            (cnt),
  .reload_val     (reload_val)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cfg_wait = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic       cfg_rmode = 1'b0;
  logic       div_sel = 1'b0;
  logic       lowspd = 1'b0;
  logic       hold = 1'b0;
  logic       irq;
  logic       rst_req;

  int checks = 0;
  int fails = 0;
  int k = 0;
  int first_irq = 0;
  int last_irq = 0;
  int first_rr = 0;
  int n_irq = 0;
  int k0 = 0;

  always #5 clk = ~clk;

  wdog_keyed uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cfg_start_wait_i(cfg_wait),
    .cfg_reload_sel_i(cfg_sel), .cfg_rst_mode_i(cfg_rmode),
    .div_sel_i(div_sel), .lowspd_i(lowspd), .hold_i(hold),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    k++;
    #1;
    if (irq) begin
      n_irq++;
      last_irq = k;
      if (first_irq == 0) first_irq = k;
    end
    if (rst_req && first_rr == 0) first_rr = k;
  endtask

  task automatic do_reset(input bit w, input logic [1:0] s, input bit rm,
                          input bit ds, input bit ls);
    cfg_wait = w; cfg_sel = s; cfg_rmode = rm; div_sel = ds; lowspd = ls;
    hold = 1'b0; rst = 1'b1;
    repeat (3) step();
    chk(irq == 1'b0 && rst_req == 1'b0, "R1 outputs in reset", {irq, rst_req}, 0);
    rst = 1'b0;
    k = 0; first_irq = 0; last_irq = 0; first_rr = 0; n_irq = 0;
  endtask

  task automatic run_to(input int target);
    while (k < target) step();
  endtask

  task automatic run_until_irq(input int limit);
    while (first_irq == 0 && k < limit) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: first cycle after reset, still quiet
    do_reset(1'b0, 2'b11, 1'b0, 1'b0, 1'b1);
    step();
    chk(irq == 1'b0 && rst_req == 1'b0, "R1 after release", {irq, rst_req}, 0);

    // R3 R4: slow clock n=2, code 11b -> 3FFFh, period 2*16384
    run_until_irq(40000);
    chk(first_irq == 2 * 16384, "R3/R4 n=2 m=3FFF", first_irq, 2 * 16384);

    // R4: code 01b -> 0FFFh, div_sel ignored under slow clock (R3)
    do_reset(1'b0, 2'b01, 1'b0, 1'b1, 1'b1);
    run_until_irq(10000);
    chk(first_irq == 2 * 4096, "R4 code01 R3 override", first_irq, 2 * 4096);

    // R4: code 10b -> 1FFFh
    do_reset(1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
    run_until_irq(20000);
    chk(first_irq == 2 * 8192, "R4 code10", first_irq, 2 * 8192);

    // R2: n=16, code 00b -> 03FFh
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    run_until_irq(20000);
    chk(first_irq == 16 * 1024, "R2 n=16 m=3FF", first_irq, 16 * 1024);

    // R2: n=128 gives no underflow before 128*1024 (window of 20000)
    do_reset(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    run_to(20000);
    chk(first_irq == 0, "R2 n=128 no early underflow", first_irq, 0);

    // R5 R7: refresh at edge 20, first tick at 16 already passed
    // next tick 32, then 1023 more -> 32 + 1023*16 = 16400
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    run_to(18);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hFF);
    run_until_irq(20000);
    chk(first_irq == 16400, "R5/R7 refresh keeps prescaler phase", first_irq, 16400);

    // R6: 00h, 55h, FFh is not a refresh; nominal period stays
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    run_to(18);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h55);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    run_until_irq(20000);
    chk(first_irq == 16384, "R6 broken key ignored", first_irq, 16384);

    // R10: n=2 m=3FF, pulse one cycle, repeats at 4096
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    run_until_irq(5000);
    chk(first_irq == 2048, "R10 first underflow", first_irq, 2048);
    step();
    chk(irq == 1'b0, "R10 pulse width one", irq, 0);
    run_to(4096);
    chk(n_irq == 2 && last_irq == 4096, "R10 periodic", last_irq, 4096);

    // R9: 300 held edges shift the underflow by 300
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    run_to(100);
    hold = 1'b1;
    run_to(400);
    hold = 1'b0;
    run_until_irq(5000);
    chk(first_irq == 2048 + 300, "R9 hold freezes", first_irq, 2348);

    // R8: wait mode idles until a start write; second start no effect
    do_reset(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
    run_to(500);
    chk(first_irq == 0, "R8 idle before start", first_irq, 0);
    wr(2'd1, 8'h5A);
    k0 = k;
    run_to(k0 + 700);
    wr(2'd1, 8'h00);
    run_until_irq(k0 + 5000);
    chk(first_irq - k0 == 2048, "R8 start then period", first_irq - k0, 2048);

    // R11: reset mode raises sticky request, no interrupt
    do_reset(1'b0, 2'b00, 1'b1, 1'b0, 1'b1);
    run_to(2100);
    chk(first_rr == 2048, "R11 request time", first_rr, 2048);
    chk(n_irq == 0, "R11 no irq", n_irq, 0);
    run_to(2200);
    chk(rst_req == 1'b1, "R11 request sticky", rst_req, 1);
    do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    step();
    chk(rst_req == 1'b0, "R11 cleared by reset", rst_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule